// File: doc/BRIEF.md
# Dual-Bus Address Decode Router

This block sits behind two bus arbiters, the primary system-bus arbiter and the secondary local-bus arbiter. It takes one transaction at a time from whichever arbiter granted it and decides where it goes. It compares the address against a bank of base/mask windows. The lowest-numbered valid window that matches picks the memory controller flavour and the target bus.

The outcome depends on two things: which arbiter granted the request, and the bus the matching window names. A system-granted request aimed at a local window is passed across the system-to-local bridge. A local-granted request aimed at a system window is discarded, because no path runs the other way. An address outside every valid window is flagged as unmapped. Accepted requests marked global wait a programmable number of cycles, so that a snooper can answer with a retry. A retry in that window aborts the access. Successive local-bus starts are spaced at least five cycles apart. The memory state machines themselves lie outside this block.

Top module: `dbus_route`

## Requirements
- R1: With `ready` high, a request on `req_valid` is decoded against every bank i whose `cfg_valid[i]` is 1 and for which `((req_addr ^ base_i) & mask_i) == 0`. The lowest such i wins and is reported on `go_bank`. Its select field `cfg_sel[3i+2:3i]` is decoded as follows: bit 2 is the bus (0 system, 1 local), and bits 1:0 are the controller (0 SDRAM, 1 programmable machine, 2 chip-select). The controller code appears on `go_mach`.
- R2: When a request routes, the bus is the bank's bus bit. `go_bridge` is 1 exactly when the system arbiter (`req_src`=0) granted a request to a local bank. A request from the local arbiter (`req_src`=1) to a local bank starts with `go_bridge`=0.
- R3: A request from the local arbiter that matches a system-bus bank produces a one-cycle `dropped` pulse, in the cycle after acceptance, and no `go`.
- R4: A request that matches no valid bank produces a one-cycle `unmapped` pulse, in the cycle after acceptance, and no `go`.
- R5: When a start targets the local bus, `go_addr` carries only the 18 low address bits, and its upper bits are zero. A start on the system bus carries the full address.
- R6: A request with `req_glob`=0 gives a one-cycle `go` two cycles after the accepting clock edge. With `req_glob`=1, `go` comes `cfg_snoop_dly` cycles later than that.
- R7: If `retry` is high at a clock edge while a global request is still in its snoop wait, the request ends with a one-cycle `aborted` pulse and no `go`.
- R8: Two `go` pulses to the local bus are at least five cycles apart. A local start that becomes ready sooner is held until the spacing is met.
- R9: After reset, `ready` is high, and `go`, `dropped`, `unmapped` and `aborted` are low.
- R10: `ready` is low from acceptance until the request ends with `go` or `aborted`. A `req_valid` presented while `ready` is low is ignored and causes no outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_base | input | NBANK*AW | Base address per bank |
| cfg_mask | input | NBANK*AW | Compare mask per bank (1 = bit compared) |
| cfg_valid | input | NBANK | Bank enable |
| cfg_sel | input | NBANK*3 | Per-bank bus bit and controller code |
| cfg_snoop_dly | input | DW | Snoop wait length in cycles |
| req_valid | input | 1 | Granted request present |
| req_src | input | 1 | Granting arbiter: 0 system, 1 local |
| req_glob | input | 1 | Global (snooped) attribute |
| req_addr | input | AW | Request address |
| retry | input | 1 | Address retry from a snooper |
| ready | output | 1 | Router can accept a request |
| go | output | 1 | Memory access start pulse |
| go_bus | output | 1 | Target bus of the start (1 local) |
| go_bridge | output | 1 | Start crosses the system-to-local bridge |
| go_mach | output | 2 | Controller code of the start |
| go_bank | output | $clog2(NBANK) | Winning bank index |
| go_addr | output | AW | Address driven with the start |
| dropped | output | 1 | Local-granted request to a system bank discarded |
| unmapped | output | 1 | No bank matched |
| aborted | output | 1 | Global request retried during the wait |

## Verification
A wrong priority or a stale decode shows up at once as the wrong `go_bank` or `go_mach` on the start pulse, two cycles after acceptance. A broken arbiter/bus combination table shows up in the same cycle as a start where a drop was due, or the reverse. A miscounted snoop or spacing counter moves the `go` pulse by a cycle or more, so the bench records the exact cycle of every outcome rather than only its kind. A pending flag that clears too early shows up as a second outcome caused by a request that should have been ignored.

// File: rtl/dbus_route.sv
module dbus_route #(
  parameter int NBANK = 12,
  parameter int AW    = 32,
  parameter int LAW   = 18,
  parameter int DW    = 4,
  parameter int LGAP  = 5,
  localparam int IW   = $clog2(NBANK),
  localparam int GW   = $clog2(LGAP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBANK*AW-1:0] cfg_base,
  input  logic [NBANK*AW-1:0] cfg_mask,
  input  logic [NBANK-1:0]  cfg_valid,
  input  logic [NBANK*3-1:0] cfg_sel,
  input  logic [DW-1:0]     cfg_snoop_dly,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic              req_glob,
  input  logic [AW-1:0]     req_addr,
  input  logic              retry,
  output logic              ready,
  output logic              go,
  output logic              go_bus,
  output logic              go_bridge,
  output logic [1:0]        go_mach,
  output logic [IW-1:0]     go_bank,
  output logic [AW-1:0]     go_addr,
  output logic              dropped,
  output logic              unmapped,
  output logic              aborted
);

  logic          hit;
  logic [IW-1:0] hidx;
  logic [2:0]    hsel;

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    hsel = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (cfg_valid[i] &&
          (((req_addr ^ cfg_base[i*AW +: AW]) & cfg_mask[i*AW +: AW]) == '0)) begin
        hit  = 1'b1;
        hidx = i[IW-1:0];
        hsel = cfg_sel[i*3 +: 3];
      end
    end
  end

  logic          pend;
  logic [DW-1:0] cnt;
  logic [GW-1:0] gap;

  assign ready = !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      cnt       <= '0;
      gap       <= '0;
      go        <= 1'b0;
      dropped   <= 1'b0;
      unmapped  <= 1'b0;
      aborted   <= 1'b0;
      go_bus    <= 1'b0;
      go_bridge <= 1'b0;
      go_mach   <= '0;
      go_bank   <= '0;
      go_addr   <= '0;
    end else begin
      go       <= 1'b0;
      dropped  <= 1'b0;
      unmapped <= 1'b0;
      aborted  <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      if (!pend) begin
        if (req_valid) begin
          if (!hit) unmapped <= 1'b1;
          else if (req_src && !hsel[2]) dropped <= 1'b1;
          else begin
            pend      <= 1'b1;
            go_bus    <= hsel[2];
            go_bridge <= !req_src && hsel[2];
            go_mach   <= hsel[1:0];
            go_bank   <= hidx;
            go_addr   <= hsel[2] ? {{(AW-LAW){1'b0}}, req_addr[LAW-1:0]} : req_addr;
            cnt       <= req_glob ? cfg_snoop_dly : '0;
          end
        end
      end else if (cnt != '0) begin
        if (retry) begin
          aborted <= 1'b1;
          pend    <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (!go_bus || gap == '0) begin
        go   <= 1'b1;
        pend <= 1'b0;
        if (go_bus) gap <= GW'(LGAP - 1);
      end
    end
  end

endmodule

// File: rtl/dbus_route_chk.sv
module dbus_route_chk #(
  parameter int AW   = 32,
  parameter int LAW  = 18,
  parameter int LGAP = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          go,
  input logic          go_bus,
  input logic          go_bridge,
  input logic [AW-1:0] go_addr,
  input logic          dropped,
  input logic          unmapped,
  input logic          aborted
);

  int   since;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= 0;
      seen  <= 1'b0;
    end else if (go && go_bus) begin
      since <= 1;
      seen  <= 1'b1;
    end else if (since < LGAP) begin
      since <= since + 1;
    end
  end

  a_r3_r4_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go, dropped, unmapped, aborted}));

  a_r2_bridge_is_local: assert property (@(posedge clk) disable iff (rst)
    go && go_bridge |-> go_bus);

  a_r5_local_addr_narrow: assert property (@(posedge clk) disable iff (rst)
    go && go_bus |-> go_addr[AW-1:LAW] == '0);

  a_r8_local_spacing: assert property (@(posedge clk) disable iff (rst)
    go && go_bus && seen |-> since >= LGAP);

  a_r10_ready_after_go: assert property (@(posedge clk) disable iff (rst)
    go || aborted |-> ready);

endmodule

bind dbus_route dbus_route_chk #(.AW(AW), .LAW(LAW), .LGAP(LGAP)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .go(go), .go_bus(go_bus),
  .go_bridge(go_bridge), .go_addr(go_addr), .dropped(dropped),
  .unmapped(unmapped), .aborted(aborted)
);

// File: tb/test_dbus_route.sv
`timescale 1ns/1ps
module test_dbus_route;
  localparam int NBANK = 12, AW = 32, DW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [NBANK*AW-1:0] cfg_base, cfg_mask;
  logic [NBANK-1:0] cfg_valid;
  logic [NBANK*3-1:0] cfg_sel;
  logic [DW-1:0] cfg_snoop_dly;
  logic req_valid = 0, req_src = 0, req_glob = 0, retry = 0;
  logic [AW-1:0] req_addr = '0;
  logic ready, go, go_bus, go_bridge, dropped, unmapped, aborted;
  logic [1:0] go_mach;
  logic [3:0] go_bank;
  logic [AW-1:0] go_addr;

  always #2.5 clk = ~clk;

  dbus_route i_dbus_route (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_snoop_dly(cfg_snoop_dly),
    .req_valid(req_valid), .req_src(req_src), .req_glob(req_glob),
    .req_addr(req_addr), .retry(retry), .ready(ready), .go(go),
    .go_bus(go_bus), .go_bridge(go_bridge), .go_mach(go_mach),
    .go_bank(go_bank), .go_addr(go_addr), .dropped(dropped),
    .unmapped(unmapped), .aborted(aborted));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {src, kind(0 go,1 drop,2 unmapped), bus, bridge, mach, bank, addr}
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 32'h0000_1234},
    {1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 4'd1, 32'h1234_5678},
    {1'b1, 2'd0, 1'b1, 1'b0, 2'd1, 4'd1, 32'h1000_0040},
    {1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 4'd0, 32'h0000_0010},
    {1'b0, 2'd0, 1'b1, 1'b1, 2'd2, 4'd3, 32'h2ABC_DEF0},
    {1'b0, 2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 32'h3000_0000},
    {1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 32'hF000_0000},
    {1'b1, 2'd0, 1'b1, 1'b0, 2'd2, 4'd3, 32'h2000_0004}
  };

  int ev_kind, ev_k, n_ev;
  logic c_bus, c_bridge;
  logic [1:0] c_mach;
  logic [3:0] c_bank;
  logic [AW-1:0] c_addr;

  task automatic run_one(input bit src, input bit glob, input logic [AW-1:0] addr,
                         input int retry_at, input int inject_at);
    ev_kind = -1; ev_k = -1; n_ev = 0;
    @(negedge clk);
    req_valid = 1; req_src = src; req_glob = glob; req_addr = addr;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      req_valid = 0; retry = 0;
      if (go || dropped || unmapped || aborted) begin
        n_ev++;
        if (ev_k < 0) begin
          ev_k = k;
          ev_kind = go ? 0 : dropped ? 1 : unmapped ? 2 : 3;
          c_bus = go_bus; c_bridge = go_bridge; c_mach = go_mach;
          c_bank = go_bank; c_addr = go_addr;
        end
      end
      if (k == retry_at) retry = 1;
      if (k == inject_at) begin
        req_valid = 1; req_src = 0; req_glob = 0; req_addr = 32'h3000_0000;
      end
    end
  endtask

  initial begin
    cfg_base = '0; cfg_mask = '0; cfg_valid = '0; cfg_sel = '0; cfg_snoop_dly = 0;
    cfg_base[0*AW +: AW] = 32'h0000_0000; cfg_mask[0*AW +: AW] = 32'hF000_0000; cfg_sel[0*3 +: 3] = 3'b000; cfg_valid[0] = 1;
    cfg_base[1*AW +: AW] = 32'h1000_0000; cfg_mask[1*AW +: AW] = 32'hF000_0000; cfg_sel[1*3 +: 3] = 3'b101; cfg_valid[1] = 1;
    cfg_base[2*AW +: AW] = 32'h2000_0000; cfg_mask[2*AW +: AW] = 32'hF000_0000; cfg_sel[2*3 +: 3] = 3'b000; cfg_valid[2] = 0;
    cfg_base[3*AW +: AW] = 32'h2000_0000; cfg_mask[3*AW +: AW] = 32'hF000_0000; cfg_sel[3*3 +: 3] = 3'b110; cfg_valid[3] = 1;
    cfg_base[4*AW +: AW] = 32'h1000_0000; cfg_mask[4*AW +: AW] = 32'hF000_0000; cfg_sel[4*3 +: 3] = 3'b001; cfg_valid[4] = 1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(ready === 1'b1, "R9 ready", ready, 1);
    check({go, dropped, unmapped, aborted} === 4'b0, "R9 outputs", {go, dropped, unmapped, aborted}, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a, ea;
      int kind;
      a = VEC[v][31:0];
      kind = int'(VEC[v][41:40]);
      run_one(VEC[v][42], 1'b0, a, 0, 0);
      check(ev_kind == kind && n_ev == 1, "R1 R3 R4 outcome kind", ev_kind, kind);
      check(ev_k == (kind == 0 ? 2 : 1), "R6 outcome cycle", ev_k, kind == 0 ? 2 : 1);
      if (kind == 0) begin
        ea = VEC[v][39] ? (a & 32'h0003_FFFF) : a;
        check(c_bank == VEC[v][35:32] && c_mach == VEC[v][37:36], "R1 bank/mach",
              {c_bank, c_mach}, {VEC[v][35:32], VEC[v][37:36]});
        check(c_bus == VEC[v][39] && c_bridge == VEC[v][38], "R2 bus/bridge",
              {c_bus, c_bridge}, {VEC[v][39], VEC[v][38]});
        check(c_addr == ea, "R5 address", c_addr, ea);
      end
    end

    // R6: global wait of 3 cycles
    cfg_snoop_dly = 3;
    run_one(1'b0, 1'b1, 32'h0000_0100, 0, 0);
    check(ev_kind == 0 && ev_k == 5, "R6 global delay", ev_k, 5);
    // R6: global with zero delay behaves like plain
    cfg_snoop_dly = 0;
    run_one(1'b0, 1'b1, 32'h0000_0100, 0, 0);
    check(ev_kind == 0 && ev_k == 2, "R6 zero delay", ev_k, 2);
    // R7: retry during wait aborts
    cfg_snoop_dly = 3;
    run_one(1'b0, 1'b1, 32'h0000_0200, 1, 0);
    check(ev_kind == 3 && ev_k == 2 && n_ev == 1, "R7 abort", ev_kind, 3);
    // R10: request while busy ignored
    run_one(1'b0, 1'b1, 32'h0000_0300, 0, 1);
    check(ev_kind == 0 && ev_k == 5 && n_ev == 1, "R10 busy ignored", n_ev, 1);
    cfg_snoop_dly = 0;

    // R8: back-to-back local starts spaced five cycles
    begin
      int t1, t2, t;
      t1 = -1; t2 = -1; t = 0;
      @(negedge clk);
      req_valid = 1; req_src = 1; req_glob = 0; req_addr = 32'h1000_0000;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        req_valid = 0;
        if (go) begin
          if (t1 < 0) begin
            t1 = k;
            req_valid = 1; req_src = 1; req_addr = 32'h2000_0008;
          end else if (t2 < 0) t2 = k;
        end
      end
      check(t1 > 0 && t2 - t1 == 5, "R8 local spacing", t2 - t1, 5);
    end
    // R8: system start not held by local spacing
    run_one(1'b1, 1'b0, 32'h1000_0000, 0, 0);
    run_one(1'b0, 1'b0, 32'h0000_0000, 0, 0);
    check(ev_kind == 0 && ev_k == 2 && c_bus == 0, "R8 system unaffected", ev_k, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule